// File: doc/BRIEF.md
# Manchester Current-Loop Frame Transmitter

This block turns one sensor sample into a Manchester-coded frame for a two-wire current-loop bus. It takes a two's-complement data word of 8 or 10 bits and an optional 3-bit state vector that says what the data word means. From these it forms a frame with the following fields, in transmission order:

- two fixed start bits
- the state vector, when it is enabled
- the data bits
- a check field, either a 3-bit CRC or a single parity bit

The frame is sent on one output, `mod_en`. When `mod_en` is high, the line draws modulation current. When it is low, the line is idle.

A frame can be launched in two ways. In timed mode, an internal period timer launches frames by itself. The period can be doubled, for example for a slower start-up data phase. In strobed mode, a frame is launched only after a sync strobe from the receiver. The block captures all frame content at the moment of launch. While a frame is on the line, `busy` is high and further launch requests are dropped.

Top module: `manchester_frame_tx`

## Requirements
- R1: Each bit lasts BIT_CYC clock cycles, split into two halves of BIT_CYC/2 cycles. A 1 is sent as low then high (a rising mid-bit edge). A 0 is sent as high then low (a falling mid-bit edge). Bits are sent MSB first.
- R2: Every frame opens with a start bit of value 1, followed by a start bit of value 0.
- R3: When `cfg_sv_en` is 1, the three bits of `sv_in` follow the start bits, MSB first. When `cfg_sv_en` is 0, no state vector bits are sent.
- R4: When `cfg_wide` is 1, the data field is `data_in[9:0]`. When `cfg_wide` is 0, the data field is `data_in[7:0]` and bits 9:8 are ignored. Codes pass through unchanged, including the reserved status codes 0x80 and 0x200.
- R5: The last field is the check field.
  - When `cfg_crc` is 1, it is 3 bits: the remainder of (message × x^3) divided by x^3+x+1. The message is every preceding bit of the frame, including the start bits, taken MSB first with a zero start value.
  - When `cfg_crc` is 0, it is one parity bit that makes the total count of 1s in the frame even.
- R6: When `cfg_sync` is 0, a frame is launched every PERIOD_CYC cycles, or every 2×PERIOD_CYC cycles when `cfg_long` is 1. The first launch comes PERIOD_CYC cycles after reset. In this mode `sync_pulse` has no effect.
- R7: When `cfg_sync` is 1, a frame starts in the cycle after `sync_pulse` is sampled high while the block is idle. The timer launches nothing in this mode.
- R8: `busy` rises in the cycle after a launch and stays high for exactly (frame bits × BIT_CYC) cycles. Any launch request while `busy` is high is ignored. Changing the inputs during a frame has no effect on that frame.
- R9: During reset and between frames, `mod_en` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sync | input | 1 | 1: launch on sync strobe; 0: launch on internal timer |
| cfg_long | input | 1 | Doubles the timer period |
| cfg_sv_en | input | 1 | Includes the state vector in the frame |
| cfg_wide | input | 1 | 1: 10-bit data field; 0: 8-bit data field |
| cfg_crc | input | 1 | 1: 3-bit CRC check field; 0: even parity bit |
| sync_pulse | input | 1 | Sync strobe from the receiver |
| data_in | input | 10 | Two's-complement sample |
| sv_in | input | 3 | State vector code |
| mod_en | output | 1 | High while modulation current is drawn |
| busy | output | 1 | High while a frame is on the line |

## Verification
The test patterns and what each one distinguishes:

- **Timed launches.** Frames are launched by the timer at both period lengths. The measured spacing between frames separates a correct period from an off-by-one count or a missing doubling.
- **Strobed frames, field widths.** Strobed frames are sent with and without the state vector, with 8-bit and 10-bit data, and with CRC and parity. Comparing each variant exposes fields that are misplaced or wrongly sized.
- **Strobed frames, data patterns.** The data words include alternating bits, all ones, and the reserved most-negative codes. These show a wrong Manchester polarity, a dropped MSB, and a CRC that leaves out the start bits.
- **Mid-frame stimulus.** Strobes arriving during a frame, and inputs toggled during a frame, show whether a request is wrongly accepted while busy and whether content is captured late.

// File: rtl/manchester_frame_tx.sv
module manchester_frame_tx #(
  parameter int BIT_CYC    = 8,
  parameter int PERIOD_CYC = 11400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sync,
  input  logic       cfg_long,
  input  logic       cfg_sv_en,
  input  logic       cfg_wide,
  input  logic       cfg_crc,
  input  logic       sync_pulse,
  input  logic [9:0] data_in,
  input  logic [2:0] sv_in,
  output logic       mod_en,
  output logic       busy
);
  localparam int HALF   = BIT_CYC / 2;
  localparam int HCW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LIM_S  = PERIOD_CYC;
  localparam int LIM_L  = 2 * PERIOD_CYC;
  localparam int TW     = $clog2(LIM_L + 1);
  localparam int FMAX   = 18;

  function automatic logic [FMAX+4:0] pack_frame(input logic sv_en, input logic wide,
      input logic crc, input logic [2:0] sv, input logic [9:0] d);
    logic [14:0] msg;
    logic [FMAX-1:0] f;
    logic [2:0] c;
    logic p, b, fb;
    int mlen;
    msg = '0;
    msg[14:13] = 2'b10;
    mlen = 2;
    if (sv_en) begin
      msg[12:10] = sv;
      mlen = 5;
    end
    if (wide) begin
      msg[14-mlen -: 10] = d;
      mlen = mlen + 10;
    end else begin
      msg[14-mlen -: 8] = d[7:0];
      mlen = mlen + 8;
    end
    c = '0;
    p = 1'b0;
    for (int i = 0; i < 15; i++) begin
      if (i < mlen) begin
        b  = msg[14-i];
        fb = b ^ c[2];
        c  = {c[1:0], 1'b0} ^ {1'b0, fb, fb};
        p  = p ^ b;
      end
    end
    f = {msg, 3'b000};
    if (crc) begin
      f[17-mlen -: 3] = c;
      mlen = mlen + 3;
    end else begin
      f[17-mlen] = p;
      mlen = mlen + 1;
    end
    return {5'(mlen), f};
  endfunction

  logic [FMAX-1:0] sh;
  logic [4:0]      left;
  logic [HCW-1:0]  hc;
  logic            ph;
  logic [TW-1:0]   tmr;
  logic            tick, launch;
  logic [FMAX+4:0] frame;

  assign tick   = tmr >= (cfg_long ? TW'(LIM_L - 1) : TW'(LIM_S - 1));
  assign launch = cfg_sync ? sync_pulse : tick;
  assign frame  = pack_frame(cfg_sv_en, cfg_wide, cfg_crc, sv_in, data_in);
  assign mod_en = busy & ~(sh[FMAX-1] ^ ph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr  <= '0;
      sh   <= '0;
      left <= '0;
      hc   <= '0;
      ph   <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (cfg_sync || tick) tmr <= '0;
      else                  tmr <= tmr + 1'b1;
      if (!busy) begin
        if (launch) begin
          {left, sh} <= frame;
          busy <= 1'b1;
          hc   <= '0;
          ph   <= 1'b0;
        end
      end else if (hc == HCW'(HALF - 1)) begin
        hc <= '0;
        ph <= ~ph;
        if (ph) begin
          sh   <= {sh[FMAX-2:0], 1'b0};
          left <= left - 1'b1;
          if (left == 5'd1) busy <= 1'b0;
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  logic [4:0] chk_len;
  int         chk_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_len <= '0;
      chk_cnt <= 0;
    end else if (!busy && launch) begin
      chk_len <= frame[FMAX+4:FMAX];
      chk_cnt <= 0;
    end else if (busy) begin
      chk_cnt <= chk_cnt + 1;
    end
  end

  assert_busy_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> chk_cnt == int'(chk_len) * BIT_CYC);

  assert_mid_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(ph)) |-> (mod_en != $past(mod_en)));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!mod_en && !ph));

  assert_launch_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_sync ? sync_pulse : tick));
endmodule

// File: tb/manchester_frame_tx_tb.sv
module manchester_frame_tx_tb;
  localparam int BIT_CYC = 4;
  localparam int HALF    = BIT_CYC / 2;
  localparam int PER     = 100;

  logic clk = 0, rst_n = 0;
  logic cfg_sync = 0, cfg_long = 0, cfg_sv_en = 0, cfg_wide = 0, cfg_crc = 0;
  logic sync_pulse = 0;
  logic [9:0] data_in = '0;
  logic [2:0] sv_in = '0;
  logic mod_en, busy;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;
  string cur_req = "R9";

  manchester_frame_tx #(.BIT_CYC(BIT_CYC), .PERIOD_CYC(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_long(cfg_long),
    .cfg_sv_en(cfg_sv_en), .cfg_wide(cfg_wide), .cfg_crc(cfg_crc),
    .sync_pulse(sync_pulse), .data_in(data_in), .sv_in(sv_in),
    .mod_en(mod_en), .busy(busy));

  always #10 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic make_frame(input bit sv_en, input bit wide, input bit crc,
      input logic [2:0] sv, input logic [9:0] d, output longint w, output int n);
    longint m, r;
    int ones;
    m = 2; n = 2;
    if (sv_en) begin m = (m << 3) | sv; n += 3; end
    if (wide) begin m = (m << 10) | d; n += 10; end
    else      begin m = (m << 8) | d[7:0]; n += 8; end
    if (crc) begin
      r = m << 3;
      for (int i = 62; i >= 3; i--)
        if (r[i]) r = r ^ (longint'(11) << (i - 3));
      w = (m << 3) | (r & 7);
      n += 3;
    end else begin
      ones = $countones(m);
      w = (m << 1) | (ones % 2);
      n += 1;
    end
  endtask

  bit     q[$];
  int     mtmr = 0;
  bit     m_busy_pre, m_go;
  int     m_lim, m_n;
  longint m_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      mtmr = 0;
    end else begin
      m_busy_pre = q.size() != 0;
      m_lim = cfg_long ? 2 * PER : PER;
      m_go  = cfg_sync ? sync_pulse : (mtmr >= m_lim - 1);
      if (cfg_sync || mtmr >= m_lim - 1) mtmr = 0;
      else mtmr++;
      if (q.size() != 0) void'(q.pop_front());
      if (!m_busy_pre && m_go) begin
        make_frame(cfg_sv_en, cfg_wide, cfg_crc, sv_in, data_in, m_w, m_n);
        for (int j = m_n - 1; j >= 0; j--) begin
          for (int h = 0; h < HALF; h++) q.push_back(~m_w[j]);
          for (int h = 0; h < HALF; h++) q.push_back(m_w[j]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check({cur_req, " mod_en"}, mod_en, (q.size() != 0) ? q[0] : 1'b0);
      check({cur_req, " busy"}, busy, q.size() != 0);
    end
  end

  task automatic send_sync(input string req, input bit sv_en, input bit wide, input bit crc,
      input logic [2:0] sv, input logic [9:0] d);
    longint w, dec;
    int n, k;
    @(negedge clk);
    cur_req = req;
    cfg_sv_en = sv_en; cfg_wide = wide; cfg_crc = crc; sv_in = sv; data_in = d;
    make_frame(sv_en, wide, crc, sv, d, w, n);
    sync_pulse = 1;
    @(negedge clk);
    sync_pulse = 0;
    check("R7 launch latency", busy, 1);
    dec = 0; k = 0;
    while (busy) begin
      if (k % BIT_CYC == HALF) dec = (dec << 1) | longint'(mod_en);
      k++;
      @(negedge clk);
      sync_pulse = (k == 5);
      if (k == 3) begin data_in = ~data_in; sv_in = ~sv_in; cfg_crc = ~cfg_crc; end
    end
    sync_pulse = 0;
    check({req, " decoded frame"}, dec, w);
    check("R8 busy length", k, n * BIT_CYC);
    repeat (3) @(negedge clk);
  endtask

  int gap;

  initial begin
    repeat (4) begin
      @(negedge clk);
      check("R9 reset mod_en", mod_en, 0);
      check("R9 reset busy", busy, 0);
    end
    cmp_on = 1;
    cfg_sv_en = 1; cfg_wide = 1; cfg_crc = 1; sv_in = 3'b101; data_in = 10'h155;
    @(negedge clk);
    rst_n = 1;
    cur_req = "R6";
    gap = 0;
    while (!busy) begin @(negedge clk); gap++; end
    check("R6 first launch", gap, PER);
    gap = 0;
    while (busy) begin @(negedge clk); gap++; sync_pulse = (gap == 20); end
    sync_pulse = 0;
    cur_req = "R9";
    while (!busy) begin @(negedge clk); gap++; end
    check("R6 period", gap, PER);
    cur_req = "R6";
    cfg_long = 1;
    while (busy) @(negedge clk);
    gap = 0;
    while (!busy) begin @(negedge clk); gap++; end
    gap = 0;
    while (busy) begin @(negedge clk); gap++; end
    while (!busy) begin @(negedge clk); gap++; end
    check("R6 long period", gap, 2 * PER);
    while (busy) @(negedge clk);
    cfg_long = 0;
    @(negedge clk);
    cfg_sync = 1;
    cur_req = "R7";
    gap = 0;
    repeat (300) begin @(negedge clk); if (busy) gap++; end
    check("R7 no timer launch", gap, 0);
    send_sync("R2", 0, 0, 0, 3'b000, 10'h000);
    send_sync("R3", 1, 0, 1, 3'b110, 10'h0A5);
    send_sync("R3", 0, 0, 1, 3'b111, 10'h0A5);
    send_sync("R4", 0, 0, 0, 3'b000, 10'h37F);
    send_sync("R4", 1, 1, 1, 3'b001, 10'h200);
    send_sync("R4", 0, 0, 1, 3'b010, 10'h080);
    send_sync("R5", 1, 1, 0, 3'b011, 10'h3FF);
    send_sync("R5", 1, 1, 1, 3'b100, 10'h2AA);
    send_sync("R1", 0, 1, 0, 3'b000, 10'h155);
    send_sync("R8", 1, 0, 0, 3'b111, 10'h0FF);
    cur_req = "R9";
    repeat (20) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule